// File: doc/BRIEF.md
# Key Matrix Strobe Scanner

This block sweeps a key matrix one row at a time. It raises one strobe line at a time, in turn, and reads four column-return lines while that strobe is active. The result for each row goes into a 4-bit holding register that belongs to that row alone. Eight rows of four returns give room for 32 keys. After every full sweep, software or a downstream state machine sees a complete eight-row snapshot of the matrix.

Each strobe dwells for a programmable number of clock cycles. The returns are captured on the last cycle of that dwell, so the matrix has the rest of the window to settle. After the last row the sweep wraps to row 0 and a one-cycle completion pulse is raised. Any row register can be read combinationally through an index port, and reading does not disturb the sweep. The read port is random access and is not a stream, so it carries no valid/ready handshake. Every pin is a plain level or pulse.

Top module: `key_strobe_scan`

## Requirements
- R1: While `scan_en` is high, exactly one bit of `strobe` is high. The active bit steps through rows 0, 1, …, 7 and then wraps back to row 0. While `scan_en` is low, `strobe` is all zero.
- R2: Each row's strobe stays high for exactly `DWELL_CYC` consecutive enabled cycles (default 16) before the next row takes over. After reset is released with `scan_en` high, row 0 is active for the first `DWELL_CYC` cycles.
- R3: On the last enabled cycle of row n's dwell, the value of `key_ret` is loaded into row register n only. Bit c of that register holds return line c. No other row register changes at that edge.
- R4: A row register keeps its value until the next capture for its own row, even if `key_ret` changes in between.
- R5: `scan_done` is high for exactly one cycle: the cycle right after row 7 is captured, which is also the first cycle of row 0's next dwell. During continuous enabled operation it repeats every 8·`DWELL_CYC` cycles.
- R6: While `scan_en` is low, the dwell count and the row position are frozen, the row registers hold their contents, and `scan_done` stays low. When `scan_en` returns high, the sweep resumes at the same row and dwell position.
- R7: Reset (`rst_n` low) clears every row register to zero, returns the sweep to row 0 with a fresh dwell, and drives `scan_done` low.
- R8: `rd_data` equals row register `rd_idx` combinationally (index 0 to 7). A value captured at a clock edge is visible from the cycle after that edge. Changing `rd_idx` never alters the strobe sequence or any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Runs the sweep when high; pauses it and idles strobes when low |
| key_ret | input | 4 | Column return lines from the key matrix, active high |
| rd_idx | input | 3 | Row register to place on `rd_data` |
| strobe | output | 8 | One-hot row strobes, bit n drives row n |
| rd_data | output | 4 | Contents of row register `rd_idx` |
| scan_done | output | 1 | One-cycle pulse after the row-7 capture completes a sweep |

## Verification
The capture of row 7, the completion pulse and a read of register 7 all land on the same clock edge. The bench holds `rd_idx` at 7 across that edge. One cycle before the edge it expects the old snapshot. One cycle after it expects the new value together with `scan_done` high, and `strobe` already back on row 0. The bench changes the matrix contents at every sweep boundary, so a capture that is off by one cycle or goes to the wrong row shows up as a mismatch in the read-back.

// File: rtl/ksc_pkg.sv
package ksc_pkg;
  localparam int unsigned KSC_ROWS  = 8;
  localparam int unsigned KSC_COLS  = 4;
  localparam int unsigned KSC_DWELL = 16;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ksc_dwell_timer.sv
module ksc_dwell_timer
  import ksc_pkg::*;
#(
  parameter int unsigned DWELL_CYC = KSC_DWELL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned CNT_W = idx_width(DWELL_CYC);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DWELL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ksc_row_seq.sv
module ksc_row_seq
  import ksc_pkg::*;
#(
  parameter int unsigned ROWS = KSC_ROWS,
  localparam int unsigned ROW_W = idx_width(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             advance,
  output logic [ROW_W-1:0] row_idx,
  output logic [ROWS-1:0]  strobe,
  output logic             wrap
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;

  assign row_idx = row_q;
  assign wrap    = advance && (row_q == ROW_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (advance) begin
      row_q <= wrap ? '0 : row_q + 1'b1;
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_strobe
    assign strobe[i] = run && (row_q == ROW_W'(i));
  end
endmodule

// File: rtl/ksc_row_bank.sv
module ksc_row_bank
  import ksc_pkg::*;
#(
  parameter int unsigned ROWS = KSC_ROWS,
  parameter int unsigned COLS = KSC_COLS,
  localparam int unsigned ROW_W = idx_width(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ROW_W-1:0]     wr_row,
  input  logic [COLS-1:0]      wr_data,
  input  logic [ROW_W-1:0]     rd_idx,
  output logic [COLS-1:0]      rd_data,
  output logic [ROWS*COLS-1:0] bank_flat
);
  logic [COLS-1:0] bank_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[r] <= '0;
      end else if (wr_en && (wr_row == ROW_W'(r))) begin
        bank_q[r] <= wr_data;
      end
    end
    assign bank_flat[r*COLS +: COLS] = bank_q[r];
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (rd_idx == ROW_W'(r)) rd_data = bank_q[r];
    end
  end
endmodule

// File: rtl/key_strobe_scan.sv
module key_strobe_scan
  import ksc_pkg::*;
#(
  parameter int unsigned ROWS      = KSC_ROWS,
  parameter int unsigned COLS      = KSC_COLS,
  parameter int unsigned DWELL_CYC = KSC_DWELL
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scan_en,
  input  logic [COLS-1:0]            key_ret,
  input  logic [idx_width(ROWS)-1:0] rd_idx,
  output logic [ROWS-1:0]            strobe,
  output logic [COLS-1:0]            rd_data,
  output logic                       scan_done
);
  localparam int unsigned ROW_W = idx_width(ROWS);

  logic             last_beat;
  logic             advance;
  logic             wrap;
  logic [ROW_W-1:0] row_idx;
  logic [ROWS*COLS-1:0] bank_flat;
  logic             done_q;

  assign advance   = scan_en && last_beat;
  assign scan_done = done_q;

  ksc_dwell_timer #(.DWELL_CYC(DWELL_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (scan_en),
    .last  (last_beat)
  );

  ksc_row_seq #(.ROWS(ROWS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (scan_en),
    .advance (advance),
    .row_idx (row_idx),
    .strobe  (strobe),
    .wrap    (wrap)
  );

  ksc_row_bank #(.ROWS(ROWS), .COLS(COLS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (advance),
    .wr_row    (row_idx),
    .wr_data   (key_ret),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .bank_flat (bank_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= wrap;
  end
endmodule

// File: rtl/ksc_scan_chk.sv
module ksc_scan_chk #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scan_en,
  input logic [ROWS-1:0]      strobe,
  input logic                 scan_done,
  input logic                 advance,
  input logic [ROWS*COLS-1:0] bank_flat
);
  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> $countones(strobe) == 1);

  // R1
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> strobe == '0);

  // R2
  strobe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && $past(scan_en) && strobe != $past(strobe)) |-> $past(advance));

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> $past(strobe[ROWS-1]) && $past(advance));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(bank_flat) && !scan_done);
endmodule

bind key_strobe_scan ksc_scan_chk #(.ROWS(ROWS), .COLS(COLS)) u_scan_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scan_en   (scan_en),
  .strobe    (strobe),
  .scan_done (scan_done),
  .advance   (advance),
  .bank_flat (bank_flat)
);

// File: tb/key_strobe_scan_bench.sv
`timescale 1ns/100ps
module key_strobe_scan_bench;
  localparam int D = 4;
  localparam int S = 8 * D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_en = 1'b0;
  logic [3:0] key_ret;
  logic [2:0] rd_idx = '0;
  logic [7:0] strobe;
  logic [3:0] rd_data;
  logic       scan_done;

  logic [3:0] matrix [8];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  key_strobe_scan #(.ROWS(8), .COLS(4), .DWELL_CYC(D)) u_key_strobe_scan (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .key_ret(key_ret),
    .rd_idx(rd_idx), .strobe(strobe), .rd_data(rd_data), .scan_done(scan_done)
  );

  // key matrix model: a return line is high when a pressed key sits on the active row
  always_comb begin
    key_ret = '0;
    for (int r = 0; r < 8; r++)
      if (strobe[r]) key_ret = key_ret | matrix[r];
  end

  function automatic logic [3:0] pat(input int p, input int r);
    case (p)
      0: return 4'h0;
      1: return 4'hF;
      2: return (r == 3) ? 4'b0100 : 4'h0;
      default: return 4'((r * 7 + p * 5 + 3) ^ (r << 1));
    endcase
  endfunction

  task automatic load_pat(input int p);
    for (int r = 0; r < 8; r++) matrix[r] = pat(p, r);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic read_row(input int r, output logic [3:0] v);
    rd_idx = 3'(r);
    #0.4;
    v = rd_data;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] v;
    logic [3:0] snap [8];
    logic [7:0] s0;
    int cur_p;
    load_pat(5);
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(strobe == 8'h0, "R7 strobe in reset", strobe, 0);
    chk(scan_done == 1'b0, "R7 scan_done in reset", scan_done, 0);
    for (int r = 0; r < 8; r++) begin
      read_row(r, v);
      chk(v == 4'h0, "R7 row register cleared", v, 0);
    end

    rst_n = 1'b1;
    @(negedge clk);
    cur_p = 0;
    load_pat(cur_p);
    scan_en = 1'b1;
    for (int k = 0; k <= 6 * S; k++) begin
      if (k > 0) @(negedge clk);
      #0.4;
      // R1 R2 strobe order and dwell length
      chk(strobe == 8'(1 << ((k / D) % 8)), "R1/R2 strobe position", strobe, 1 << ((k / D) % 8));
      // R5 completion pulse timing
      chk(scan_done == (k > 0 && k % S == 0), "R5 scan_done", scan_done, (k > 0 && k % S == 0));
      if (k % S == S - 1) begin
        read_row(7, v);
        // R4 old snapshot still held just before the row-7 capture
        chk(v == ((k < S) ? 4'h0 : pat(cur_p - 1, 7)), "R4 row7 before capture", v,
            (k < S) ? 0 : pat(cur_p - 1, 7));
      end
      if (k > 0 && k % S == 0) begin
        // R8 new row-7 value visible in the cycle after capture
        read_row(7, v);
        chk(v == pat(cur_p, 7), "R8 row7 after capture", v, pat(cur_p, 7));
        chk(strobe[0] == 1'b1, "R5 row0 resumes with scan_done", strobe, 1);
        for (int r = 0; r < 8; r++) begin
          read_row(r, v);
          // R3 each row register holds its own row's returns
          chk(v == pat(cur_p, r), "R3 captured row", v, pat(cur_p, r));
        end
        cur_p++;
        load_pat(cur_p);
      end
    end

    // R6 pause mid-dwell
    repeat (3 * D + 1) @(negedge clk);
    #0.4;
    s0 = strobe;
    chk(s0 == 8'h08, "R2 position before pause", s0, 8'h08);
    for (int r = 0; r < 8; r++) read_row(r, snap[r]);
    scan_en = 1'b0;
    load_pat(1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      #0.4;
      chk(strobe == 8'h0, "R6 strobes idle", strobe, 0);
      chk(scan_done == 1'b0, "R6 no scan_done", scan_done, 0);
    end
    for (int r = 0; r < 8; r++) begin
      read_row(r, v);
      chk(v == snap[r], "R6 registers held", v, snap[r]);
    end
    scan_en = 1'b1;
    #0.4;
    chk(strobe == s0, "R6 resumes same row", strobe, s0);
    repeat (D - 2) @(negedge clk);
    #0.4;
    chk(strobe == s0, "R6 dwell count frozen", strobe, s0);
    @(negedge clk);
    #0.4;
    chk(strobe == 8'h10, "R6 advance after remaining dwell", strobe, 8'h10);
    read_row(3, v);
    chk(v == 4'hF, "R3 row3 captured after resume", v, 4'hF);
    read_row(2, v);
    chk(v == snap[2], "R4 row2 untouched by row3 capture", v, snap[2]);

    // R7 reset mid-sweep
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.4;
    chk(strobe == 8'h01, "R7 restart at row0", strobe, 1);
    for (int r = 0; r < 8; r++) begin
      read_row(r, v);
      chk(v == 4'h0, "R7 registers cleared mid-sweep", v, 0);
    end
    repeat (D) @(negedge clk);
    #0.4;
    chk(strobe == 8'h02, "R2 fresh dwell after reset", strobe, 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule